// File: doc/BRIEF.md
# Four-Channel Encoder Command Register Bank

This block is the host-side register front end for four serial absolute-encoder channels on a 24-bit host data bus. Every encoder transaction returns a 32-bit result, so each channel has two registers. The low register holds the 24 least significant result bits. The high register holds the 8 most significant result bits, the status byte the engine returned, and the busy flags of all channels. On a host write, the low 8 bits of any channel's low register act as a command byte.

A single accepted command write starts that command on all four channel engines at once. Each engine's busy flag is set and its low result register is cleared to zero. When an engine reports completion, its whole result and its status are latched together and its busy flag drops. After reset, the block issues a default position-read command by itself, so fresh results are waiting before the host does anything. The serial line engines sit outside the block. They receive a one-cycle start strobe with a shared command byte, and they return a done strobe, 32 data bits and a status byte per channel.

Top module: `enc_cmd_bank`

## Requirements
- R1: While `rst_n` is low, every register reads zero, no busy flag is set, and `eng_start` is 0.
- R2: After `rst_n` rises, the internal reset is released on the second rising clock edge. On the third edge, `eng_start` goes to all ones for exactly one cycle, with `eng_cmd` equal to `DEFAULT_CMD` (default 0x42). A host command write in the cycle before that edge is dropped.
- R3: A write with `wr_en` high to a low-register address (2, 10, 18 or 26) while no channel is busy makes all four `eng_start` bits pulse high for one cycle, starting at the next edge. `eng_cmd` then carries `wr_data[7:0]`, and `wr_data[23:8]` has no effect.
- R4: All busy flags are set at the edge where `eng_start` rises. Busy flags 0 to 3 read at bits 16 to 19 of every high register.
- R5: When a command starts, each channel's low register is cleared to zero. Its high register keeps its previous result byte and status byte.
- R6: If `eng_done[k]` is high while channel k is busy, then at the next edge the busy flag clears. In the same edge, the low register takes `eng_data[k][23:0]`, the high register bits 7:0 take `eng_data[k][31:24]`, and bits 15:8 take `eng_stat[k]`. A done strobe on an idle channel changes nothing.
- R7: A command write while any channel is busy is ignored. No start pulse follows and the busy flags stay as they were.
- R8: Writes to high-register addresses or to unmapped addresses start nothing and change no register.
- R9: Read data is combinational from `rd_addr`. Address 2+8k gives channel k's low register. Address 3+8k gives {4'b0, busy[3:0], status[7:0], result[31:24]}. Every other address reads zero.
- R10: Pulling `rst_n` low during an operation clears all busy flags, results and the start strobe at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle host write strobe |
| wr_addr | input | 5 | Host write address |
| wr_data | input | 24 | Host write data; bits 7:0 are the command byte |
| rd_addr | input | 5 | Host read address |
| rd_data | output | 24 | Combinational read data |
| eng_start | output | 4 | One-cycle start strobe per channel engine |
| eng_cmd | output | 8 | Command byte shared by all engines |
| eng_done | input | 4 | Completion strobe per channel engine |
| eng_data | input | 128 | 32-bit result per channel, channel k at bits 32k+31:32k |
| eng_stat | input | 32 | 8-bit status per channel, channel k at bits 8k+7:8k |

## Verification
The broadcast start is driven from every channel's low-register address. Each of these is expected to produce the same four-wide pulse, which shows that the decode does not depend on the channel. Completion is driven with all-ones, all-zero and mixed result words, one channel at a time. This separates the 24/8 split of the result and the placement of the status byte, and it shows which busy bit belongs to which channel. The block is also fed writes while busy, writes to high and unmapped addresses, done strobes on idle channels, and a reset in the middle of an operation. Each of these must leave the state unchanged or cleared, which tells ignored stimulus apart from stimulus the block accepts.

// File: rtl/enc_bank_pkg.sv
package enc_bank_pkg;
  // register pair spacing and offsets inside a channel slot
  localparam int REG_STRIDE = 8;
  localparam int LO_OFS     = 2;
  localparam int HI_OFS     = 3;

  function automatic int lo_addr(input int ch);
    return LO_OFS + ch * REG_STRIDE;
  endfunction

  function automatic int hi_addr(input int ch);
    return HI_OFS + ch * REG_STRIDE;
  endfunction
endpackage

// File: rtl/enc_rst_sync.sv
module enc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/enc_cmd_ctrl.sv
module enc_cmd_ctrl #(
  parameter int              NUM_CH      = 4,
  parameter int              CMD_W       = 8,
  parameter logic [CMD_W-1:0] DEFAULT_CMD = 8'h42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic [CMD_W-1:0]  host_cmd,
  input  logic              any_busy,
  output logic              issue,
  output logic [NUM_CH-1:0] eng_start,
  output logic [CMD_W-1:0]  eng_cmd
);
  logic             boot_q, boot_d;
  logic             start_q, start_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;

  always_comb begin
    issue   = !any_busy && (boot_q || host_req);
    boot_d  = boot_q && !issue;
    start_d = issue;
    cmd_d   = boot_q ? DEFAULT_CMD : host_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q  <= 1'b1;
      start_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      boot_q  <= boot_d;
      start_q <= start_d;
      if (issue) cmd_q <= cmd_d;
    end
  end

  assign eng_start = {NUM_CH{start_q}};
  assign eng_cmd   = cmd_q;
endmodule

// File: rtl/enc_chan_regs.sv
module enc_chan_regs #(
  parameter int DATA_W = 24,
  parameter int RES_W  = 32,
  parameter int STAT_W = 8,
  localparam int MSB_W = RES_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              done,
  input  logic [RES_W-1:0]  data,
  input  logic [STAT_W-1:0] stat,
  output logic              busy,
  output logic [DATA_W-1:0] lo,
  output logic [MSB_W-1:0]  msb,
  output logic [STAT_W-1:0] stat_q
);
  logic              busy_d, lo_en, hi_en;
  logic [DATA_W-1:0] lo_d;

  always_comb begin
    hi_en  = done && busy && !issue;
    lo_en  = issue || hi_en;
    busy_d = issue ? 1'b1 : (hi_en ? 1'b0 : busy);
    lo_d   = issue ? '0 : data[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      lo     <= '0;
      msb    <= '0;
      stat_q <= '0;
    end else begin
      busy <= busy_d;
      if (lo_en) lo <= lo_d;
      if (hi_en) begin
        msb    <= data[RES_W-1:DATA_W];
        stat_q <= stat;
      end
    end
  end
endmodule

// File: rtl/enc_rd_mux.sv
module enc_rd_mux import enc_bank_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 24,
  parameter int MSB_W  = 8,
  parameter int STAT_W = 8,
  parameter int ADDR_W = 5,
  localparam int BUSY_LSB = MSB_W + STAT_W
) (
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NUM_CH-1:0]        busy,
  input  logic [NUM_CH*DATA_W-1:0] lo_flat,
  input  logic [NUM_CH*MSB_W-1:0]  msb_flat,
  input  logic [NUM_CH*STAT_W-1:0] stat_flat,
  output logic [DATA_W-1:0]        rd_data
);
  always_comb begin
    rd_data = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (rd_addr == ADDR_W'(lo_addr(ch))) begin
        rd_data = lo_flat[ch*DATA_W +: DATA_W];
      end else if (rd_addr == ADDR_W'(hi_addr(ch))) begin
        rd_data[MSB_W-1:0]         = msb_flat[ch*MSB_W +: MSB_W];
        rd_data[MSB_W +: STAT_W]   = stat_flat[ch*STAT_W +: STAT_W];
        rd_data[BUSY_LSB +: NUM_CH] = busy;
      end
    end
  end
endmodule

// File: rtl/enc_cmd_bank.sv
module enc_cmd_bank import enc_bank_pkg::*; #(
  parameter int              NUM_CH      = 4,
  parameter int              DATA_W      = 24,
  parameter int              RES_W       = 32,
  parameter int              STAT_W      = 8,
  parameter int              CMD_W       = 8,
  parameter int              ADDR_W      = 5,
  parameter logic [CMD_W-1:0] DEFAULT_CMD = 8'h42
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NUM_CH-1:0]        eng_start,
  output logic [CMD_W-1:0]         eng_cmd,
  input  logic [NUM_CH-1:0]        eng_done,
  input  logic [NUM_CH*RES_W-1:0]  eng_data,
  input  logic [NUM_CH*STAT_W-1:0] eng_stat
);
  localparam int MSB_W = RES_W - DATA_W;

  logic                     rst_int_n;
  logic                     issue;
  logic                     host_req;
  logic [NUM_CH-1:0]        cmd_hit;
  logic [NUM_CH-1:0]        busy_vec;
  logic [NUM_CH*DATA_W-1:0] lo_flat;
  logic [NUM_CH*MSB_W-1:0]  msb_flat;
  logic [NUM_CH*STAT_W-1:0] stat_flat;
  logic                     unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:CMD_W];

  enc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
    assign cmd_hit[ch] = (wr_addr == ADDR_W'(lo_addr(ch)));
  end

  assign host_req = wr_en && (|cmd_hit);

  enc_cmd_ctrl #(
    .NUM_CH      (NUM_CH),
    .CMD_W       (CMD_W),
    .DEFAULT_CMD (DEFAULT_CMD)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .host_req  (host_req),
    .host_cmd  (wr_data[CMD_W-1:0]),
    .any_busy  (|busy_vec),
    .issue     (issue),
    .eng_start (eng_start),
    .eng_cmd   (eng_cmd)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    enc_chan_regs #(
      .DATA_W (DATA_W),
      .RES_W  (RES_W),
      .STAT_W (STAT_W)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .issue  (issue),
      .done   (eng_done[ch]),
      .data   (eng_data[ch*RES_W +: RES_W]),
      .stat   (eng_stat[ch*STAT_W +: STAT_W]),
      .busy   (busy_vec[ch]),
      .lo     (lo_flat[ch*DATA_W +: DATA_W]),
      .msb    (msb_flat[ch*MSB_W +: MSB_W]),
      .stat_q (stat_flat[ch*STAT_W +: STAT_W])
    );
  end

  enc_rd_mux #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .MSB_W  (MSB_W),
    .STAT_W (STAT_W),
    .ADDR_W (ADDR_W)
  ) u_rd_mux (
    .rd_addr   (rd_addr),
    .busy      (busy_vec),
    .lo_flat   (lo_flat),
    .msb_flat  (msb_flat),
    .stat_flat (stat_flat),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/enc_cmd_bank_chk.sv
module enc_cmd_bank_chk import enc_bank_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 24,
  parameter int ADDR_W = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [ADDR_W-1:0]        rd_addr,
  input logic [DATA_W-1:0]        rd_data,
  input logic [NUM_CH-1:0]        eng_start,
  input logic [NUM_CH-1:0]        eng_done,
  input logic [NUM_CH-1:0]        busy,
  input logic [NUM_CH*DATA_W-1:0] lo_flat
);
  logic wr_cmd_slot;
  logic rd_mapped;

  always_comb begin
    wr_cmd_slot = ((int'(wr_addr) % REG_STRIDE) == LO_OFS) &&
                  ((int'(wr_addr) / REG_STRIDE) < NUM_CH);
    rd_mapped   = (((int'(rd_addr) % REG_STRIDE) == LO_OFS) ||
                   ((int'(rd_addr) % REG_STRIDE) == HI_OFS)) &&
                  ((int'(rd_addr) / REG_STRIDE) < NUM_CH);
  end

  AST_START_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start == '0) || (eng_start == '1)); // R3

  AST_BUSY_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_start) |-> (&busy)); // R4

  AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cmd_slot && (|busy)) |=> (eng_start == '0)); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_mapped |-> (rd_data == '0)); // R9

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    AST_LO_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start[ch] |-> (lo_flat[ch*DATA_W +: DATA_W] == '0)); // R5

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[ch] && eng_done[ch]) |=> !busy[ch]); // R6

    AST_IDLE_DONE_NOEFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[ch] && eng_done[ch] && !wr_en) |=> $stable(lo_flat[ch*DATA_W +: DATA_W])); // R6
  end
endmodule

bind enc_cmd_bank enc_cmd_bank_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .eng_start (eng_start),
  .eng_done  (eng_done),
  .busy      (busy_vec),
  .lo_flat   (lo_flat)
);

// File: tb/enc_cmd_bank_tb.sv
module enc_cmd_bank_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] DEF = 8'h42;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [4:0]   wr_addr = '0;
  logic [23:0]  wr_data = '0;
  logic [4:0]   rd_addr = '0;
  logic [23:0]  rd_data;
  logic [3:0]   eng_start;
  logic [7:0]   eng_cmd;
  logic [3:0]   eng_done = '0;
  logic [127:0] eng_data = '0;
  logic [31:0]  eng_stat = '0;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #(CLK_P/2) clk = ~clk;

  enc_cmd_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .eng_start(eng_start), .eng_cmd(eng_cmd),
    .eng_done(eng_done), .eng_data(eng_data), .eng_stat(eng_stat)
  );

  // behavioural reference model
  bit         rs1, rs2, boot_m, start_m;
  bit   [3:0] busy_m;
  logic [7:0] cmd_m;
  logic [23:0] lo_m  [4];
  logic [7:0]  msb_m [4];
  logic [7:0]  st_m  [4];

  function automatic bit is_cmd_addr(input int a);
    return (a >= 2) && ((a - 2) % 8 == 0) && ((a - 2) / 8 < 4);
  endfunction

  function automatic logic [23:0] mread(input int a);
    if (a >= 2 && (a - 2) % 8 == 0 && (a - 2) / 8 < 4) return lo_m[(a - 2) / 8];
    if (a >= 3 && (a - 3) % 8 == 0 && (a - 3) / 8 < 4)
      return {4'h0, busy_m, st_m[(a - 3) / 8], msb_m[(a - 3) / 8]};
    return 24'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 = 0; rs2 = 0; boot_m = 1; start_m = 0; busy_m = 0; cmd_m = 0;
      for (int k = 0; k < 4; k++) begin lo_m[k] = 0; msb_m[k] = 0; st_m[k] = 0; end
    end else begin
      if (rs2) begin
        bit issue;
        issue = (busy_m == 0) && (boot_m || (wr_en && is_cmd_addr(int'(wr_addr))));
        if (issue) begin
          cmd_m = boot_m ? DEF : wr_data[7:0];
          boot_m = 0;
          busy_m = 4'hF;
          for (int k = 0; k < 4; k++) lo_m[k] = 0;
        end else begin
          for (int k = 0; k < 4; k++)
            if (eng_done[k] && busy_m[k]) begin
              busy_m[k] = 0;
              lo_m[k]  = eng_data[k*32 +: 24];
              msb_m[k] = eng_data[k*32+24 +: 8];
              st_m[k]  = eng_stat[k*8 +: 8];
            end
        end
        start_m = issue;
      end
      rs2 = rs1;
      rs1 = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (!finished) begin
      chk("R3 start strobe", eng_start, {4{start_m}});
      if (start_m) chk("R3 command byte", eng_cmd, cmd_m);
      chk("R9 read data", rd_data, mread(int'(rd_addr)));
    end
  end

  task automatic rd_chk(input string tag, input int a, input logic [23:0] exp);
    rd_addr = 5'(a);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic host_write(input int a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_addr = 0; wr_data = 0;
  endtask

  task automatic finish_ch(input int ch, input logic [31:0] d, input logic [7:0] s);
    @(negedge clk);
    eng_done[ch] = 1; eng_data[ch*32 +: 32] = d; eng_stat[ch*8 +: 8] = s;
    @(negedge clk);
    eng_done = 0;
  endtask

  task automatic release_and_boot();
    @(negedge clk); rst_n = 1;
    @(negedge clk); chk("R2 no start after edge 1", eng_start, 4'h0);
    @(negedge clk); chk("R2 no start after edge 2", eng_start, 4'h0);
    @(negedge clk); chk("R2 boot start", eng_start, 4'hF);
    chk("R2 boot command", eng_cmd, DEF);
    @(negedge clk); chk("R2 single pulse", eng_start, 4'h0);
    rd_chk("R4 busy after boot", 3, 24'h0F0000);
    rd_chk("R5 low cleared at boot", 2, 24'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 start in reset", eng_start, 4'h0);
    for (int a = 0; a < 32; a++) rd_chk("R1 reset read", a, 24'h0);

    release_and_boot();

    host_write(10, 24'h000011);
    chk("R7 write while busy", eng_start, 4'h0);
    rd_chk("R7 busy kept", 11, 24'h0F0000);

    finish_ch(0, 32'hA1B2C3D4, 8'h5C);
    rd_chk("R6 ch0 low", 2, 24'hB2C3D4);
    rd_chk("R6 ch0 high", 3, 24'h0E5CA1);
    finish_ch(1, 32'h00FFFF01, 8'h00);
    rd_chk("R6 ch1 low", 10, 24'hFFFF01);
    rd_chk("R4 ch1 high", 11, 24'h0C0000);
    finish_ch(2, 32'hFFFFFFFF, 8'hFF);
    rd_chk("R6 ch2 low", 18, 24'hFFFFFF);
    rd_chk("R4 ch2 high", 19, 24'h08FFFF);
    finish_ch(3, 32'h12345678, 8'h81);
    rd_chk("R6 ch3 low", 26, 24'h345678);
    rd_chk("R6 ch3 high", 27, 24'h008112);

    finish_ch(2, 32'h0, 8'h0);
    rd_chk("R6 idle done low", 18, 24'hFFFFFF);
    rd_chk("R6 idle done high", 19, 24'h00FFFF);

    host_write(3, 24'h000042);
    chk("R8 high addr write", eng_start, 4'h0);
    rd_chk("R8 high addr no change", 3, 24'h005CA1);
    host_write(5, 24'h000042);
    chk("R8 unmapped write", eng_start, 4'h0);
    rd_chk("R8 unmapped no change", 2, 24'hB2C3D4);

    host_write(26, 24'hABCD5A);
    chk("R3 start via ch3", eng_start, 4'hF);
    chk("R3 command from low byte", eng_cmd, 8'h5A);
    rd_chk("R5 low cleared", 2, 24'h0);
    rd_chk("R5 high kept", 3, 24'h0F5CA1);

    for (int k = 0; k < 4; k++) finish_ch(k, 32'h01020304 * (k + 1), 8'(k));
    host_write(2, 24'h000033);
    chk("R3 start via ch0", eng_start, 4'hF);
    chk("R3 command 0x33", eng_cmd, 8'h33);
    finish_ch(1, 32'hCAFE0001, 8'h10);

    @(negedge clk); rst_n = 0;
    #1;
    chk("R10 start cleared", eng_start, 4'h0);
    rd_chk("R10 busy cleared", 3, 24'h0);
    rd_chk("R10 result cleared", 10, 24'h0);
    repeat (2) @(negedge clk);
    release_and_boot();

    for (int k = 3; k >= 0; k--) finish_ch(k, 32'hF00D0000 + k, 8'hA0 + 8'(k));
    host_write(18, 24'h000077);
    chk("R3 start via ch2", eng_start, 4'hF);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule